// File: doc/BRIEF.md
# Analog Front-End Power-On Bring-Up Sequencer

This block brings a camera analog front-end out of power-up. On a start request it drives the device's hardware reset low for a fixed number of input clocks. It then releases the reset and leaves a settling gap before any register traffic. After that it pushes an ordered list of register writes to a serial-port engine, one transfer per valid/ready handshake.

The writes run in five groups, in this order:
- the timing-generator range;
- the four delay-line phase registers;
- a soft-reset register written with its reset bit cleared;
- after a charge wait, the same register written again with the bit set;
- a short table of remaining amplifier and sample-hold registers.

Register contents come from an external lookup port. The sequencer puts the address of the pending write on that port and takes the value back in the same cycle. After the second soft-reset write, an offset-calibration delay runs, counted in converter-clock periods. The converter clock is the input clock divided by 2 or 3, picked by a mode pin. Only when that delay has expired and the last table write is accepted does `done` rise. It stays high until the next start.

Top module: `afe_bringup_seq`

## Requirements
- R1: After synchronous reset `afe_rst_n` is 0, `wr_valid` is 0 and `done` is 0, and nothing changes until `start` is sampled high.
- R2: Once `start` is accepted, `afe_rst_n` rises exactly RST_CYC (default 3) input clocks after the edge that sampled `start`.
- R3: The first `wr_valid` rises at least SETTLE_CYC (default 6) clocks after `afe_rst_n` rises, and `wr_valid` is never high while `afe_rst_n` is 0.
- R4: A write completes on each edge where `wr_valid` and `wr_ready` are both high. While `wr_valid` is high and `wr_ready` low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R5: Write addresses follow this order:
  - 0x00 up to TG_LAST (default 0xEF), ascending;
  - 0xF4, 0xF5, 0xF6, 0xF7;
  - 0xF2 twice;
  - the EXTRA_CNT entries of EXTRA_ADDRS in index order, where entry i sits in bits [8i+7:8i].
- R6: `lut_addr` equals the address of the pending write, and `wr_data` carries `lut_data` for that address.
- R7: The first 0xF2 write has bit SRST_BIT cleared, and the second has it set. All other bits come from the lookup.
- R8: The second 0xF2 write becomes valid no sooner than CHG clocks after the first 0xF2 write completes, with CHG = (CLK_HZ/1000)·CHARGE_US/1000.
- R9: `done` rises on edge max(L, B + CAL) + 1, where:
  - B is the edge on which the second 0xF2 write completes;
  - L is the edge on which the last table write completes;
  - CAL = CAL_PERIODS·3 if `div3_mode` is 1 at edge B, and CAL_PERIODS·2 otherwise.
- R10: While `done` is high, `wr_valid` stays 0 and `done` stays high until `start`. A `start` sampled in that state clears `done` on the same edge and restarts the reset pulse.
- R11: `start` is ignored while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the bring-up from idle or done |
| div3_mode | input | 1 | 1: converter clock is input/3, 0: input/2 |
| afe_rst_n | output | 1 | Hardware reset to the front-end, active low |
| wr_valid | output | 1 | Register write request |
| wr_addr | output | AW | Register write address |
| wr_data | output | DW | Register write data |
| wr_ready | input | 1 | Serial engine accepts the write |
| lut_addr | output | AW | Lookup address (pending write) |
| lut_data | input | DW | Lookup value for `lut_addr` |
| done | output | 1 | Front-end is configured and calibrated |

## Verification
The assertions assume the following about the block's inputs:
- `lut_data` is a pure combinational function of `lut_addr` that does not change while a write is pending.
- `div3_mode` is a steady level.
- The parameters give every wait a nonzero length.

The bench keeps to these. It derives the lookup from the address and a key that changes only between sequences, and it holds the mode pin for a whole run. `wr_ready` is otherwise left unconstrained: it is random per cycle, forced high in one run, and held low for a long stretch in another. That stretch makes the last table write, not the calibration timer, decide when `done` rises.

// File: rtl/afe_seq_pkg.sv
package afe_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_SETTLE, ST_ISSUE, ST_WAIT, ST_CHARGE, ST_CALWAIT, ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    PH_TG, PH_DLL, PH_SR0, PH_SR1, PH_EXTRA
  } wr_phase_e;

  // charge wait in input clocks; split division keeps 32-bit range
  function automatic int unsigned charge_cycles(int unsigned clk_hz, int unsigned us);
    int unsigned c;
    c = (clk_hz / 1000) * us / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  // calibration wait in input clocks for the selected divider
  function automatic int unsigned cal_cycles(int unsigned periods, logic div3);
    return div3 ? periods * 3 : periods * 2;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/afe_wait_timer.sv
module afe_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         fire,
  output logic         busy
);
  logic [W-1:0] rem;

  // fire is high in the cycle before the edge that ends the wait:
  // the owner acts exactly len edges after the load edge
  assign fire = busy && (rem == W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      rem  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      rem  <= len;
    end else if (fire) begin
      busy <= 1'b0;
    end else if (busy) begin
      rem <= rem - W'(1);
    end
  end

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load |-> (len != '0)); // R8
endmodule

// File: rtl/afe_addr_gen.sv
module afe_addr_gen
  import afe_seq_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned TG_LAST   = 8'hEF,
  parameter int unsigned DLL_BASE  = 8'hF4,
  parameter int unsigned DLL_CNT   = 4,
  parameter int unsigned SRST_ADDR = 8'hF2,
  parameter int unsigned EXTRA_CNT = 4,
  parameter logic [AW*EXTRA_CNT-1:0] EXTRA_ADDRS = '0
) (
  input  wr_phase_e     phase,
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam int XW = (EXTRA_CNT > 1) ? $clog2(EXTRA_CNT) : 1;

  logic [AW-1:0] tbl [EXTRA_CNT];

  for (genvar i = 0; i < EXTRA_CNT; i++) begin : g_tbl
    assign tbl[i] = EXTRA_ADDRS[AW*i +: AW];
  end

  always_comb begin
    addr = '0;
    last = 1'b1;
    case (phase)
      PH_TG: begin
        addr = idx;
        last = (idx == AW'(TG_LAST));
      end
      PH_DLL: begin
        addr = AW'(DLL_BASE) + idx;
        last = (idx == AW'(DLL_CNT - 1));
      end
      PH_SR0, PH_SR1: begin
        addr = AW'(SRST_ADDR);
        last = 1'b1;
      end
      PH_EXTRA: begin
        addr = tbl[idx[XW-1:0]];
        last = (idx == AW'(EXTRA_CNT - 1));
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/afe_bringup_seq.sv
module afe_bringup_seq
  import afe_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned CHARGE_US   = 2000,
  parameter int unsigned CAL_PERIODS = 40000,
  parameter int unsigned RST_CYC     = 3,
  parameter int unsigned SETTLE_CYC  = 6,
  parameter int unsigned AW          = 8,
  parameter int unsigned DW          = 8,
  parameter int unsigned TG_LAST     = 8'hEF,
  parameter int unsigned DLL_BASE    = 8'hF4,
  parameter int unsigned DLL_CNT     = 4,
  parameter int unsigned SRST_ADDR   = 8'hF2,
  parameter int unsigned SRST_BIT    = 0,
  parameter int unsigned EXTRA_CNT   = 4,
  parameter logic [AW*EXTRA_CNT-1:0] EXTRA_ADDRS = {8'hF8, 8'hF3, 8'hF1, 8'hF0}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          div3_mode,
  output logic          afe_rst_n,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ready,
  output logic [AW-1:0] lut_addr,
  input  logic [DW-1:0] lut_data,
  output logic          done
);
  localparam int unsigned CHG  = charge_cycles(CLK_HZ, CHARGE_US);
  localparam int unsigned MAXW = max2(max2(CHG, cal_cycles(CAL_PERIODS, 1'b1)),
                                      max2(RST_CYC, SETTLE_CYC));
  localparam int CW = $clog2(MAXW + 1);

  seq_state_e    state;
  wr_phase_e     phase;
  logic [AW-1:0] idx;
  logic [AW-1:0] cur_addr;
  logic          cur_last;
  logic [DW-1:0] patched;
  logic          cal_ok;

  // named events shared by the FSM and the assertions
  logic ev_start, ev_accept, ev_phase_end;
  logic tm_load, tm_fire, tm_busy;
  logic [CW-1:0] tm_len;
  logic cal_load, cal_fire, cal_busy;
  logic [CW-1:0] cal_len;

  assign ev_start     = start && (state == ST_IDLE || state == ST_DONE);
  assign ev_accept    = wr_valid && wr_ready;
  assign ev_phase_end = ev_accept && cur_last;

  afe_addr_gen #(
    .AW(AW), .TG_LAST(TG_LAST), .DLL_BASE(DLL_BASE), .DLL_CNT(DLL_CNT),
    .SRST_ADDR(SRST_ADDR), .EXTRA_CNT(EXTRA_CNT), .EXTRA_ADDRS(EXTRA_ADDRS)
  ) i_addr (
    .phase(phase), .idx(idx), .addr(cur_addr), .last(cur_last)
  );

  assign wr_addr  = cur_addr;
  assign lut_addr = cur_addr;

  always_comb begin
    patched = lut_data;
    if (phase == PH_SR0) patched[SRST_BIT] = 1'b0;
    if (phase == PH_SR1) patched[SRST_BIT] = 1'b1;
  end

  // main timer: reset pulse, settle gap, charge wait
  always_comb begin
    tm_load = 1'b0;
    tm_len  = CW'(RST_CYC);
    if (ev_start) begin
      tm_load = 1'b1;
    end else if (state == ST_HOLD && tm_fire) begin
      tm_load = 1'b1;
      tm_len  = CW'(SETTLE_CYC);
    end else if (state == ST_WAIT && ev_phase_end && phase == PH_SR0) begin
      tm_load = 1'b1;
      tm_len  = CW'(CHG);
    end
  end

  afe_wait_timer #(.W(CW)) i_tm (
    .clk(clk), .rst(rst), .load(tm_load), .len(tm_len), .fire(tm_fire), .busy(tm_busy)
  );

  // calibration timer starts when the reset-release write completes
  assign cal_load = ev_accept && (phase == PH_SR1);
  assign cal_len  = CW'(cal_cycles(CAL_PERIODS, div3_mode));

  afe_wait_timer #(.W(CW)) i_cal (
    .clk(clk), .rst(rst), .load(cal_load), .len(cal_len), .fire(cal_fire), .busy(cal_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phase     <= PH_TG;
      idx       <= '0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
      afe_rst_n <= 1'b0;
      done      <= 1'b0;
      cal_ok    <= 1'b0;
    end else begin
      if (cal_fire) cal_ok <= 1'b1;
      case (state)
        ST_IDLE, ST_DONE: if (ev_start) begin
          state     <= ST_HOLD;
          afe_rst_n <= 1'b0;
          done      <= 1'b0;
          cal_ok    <= 1'b0;
          phase     <= PH_TG;
          idx       <= '0;
        end
        ST_HOLD: if (tm_fire) begin
          afe_rst_n <= 1'b1;
          state     <= ST_SETTLE;
        end
        ST_SETTLE: if (tm_fire) state <= ST_ISSUE;
        ST_ISSUE: begin
          wr_data  <= patched;
          wr_valid <= 1'b1;
          state    <= ST_WAIT;
        end
        ST_WAIT: if (wr_ready) begin
          wr_valid <= 1'b0;
          if (!cur_last) begin
            idx   <= idx + AW'(1);
            state <= ST_ISSUE;
          end else begin
            idx <= '0;
            case (phase)
              PH_TG:   begin phase <= PH_DLL;   state <= ST_ISSUE;   end
              PH_DLL:  begin phase <= PH_SR0;   state <= ST_ISSUE;   end
              PH_SR0:  begin phase <= PH_SR1;   state <= ST_CHARGE;  end
              PH_SR1:  begin phase <= PH_EXTRA; state <= ST_ISSUE;   end
              default: state <= ST_CALWAIT;
            endcase
          end
        end
        ST_CHARGE: if (tm_fire) state <= ST_ISSUE;
        ST_CALWAIT: if (cal_ok) begin
          done  <= 1'b1;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // low-time counter used only by the assertions
  logic [7:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || afe_rst_n) low_run <= '0;
    else if (low_run != 8'hFF) low_run <= low_run + 8'd1;
  end

  AST_RST_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(afe_rst_n) |-> (low_run >= 8'(RST_CYC))); // R2
  AST_HOLD_TIMES: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |-> tm_busy); // R2
  AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> afe_rst_n); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R4
  AST_CAL_RUNNING: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CALWAIT && !cal_ok) |-> cal_busy); // R9
  AST_DONE_AFTER_CAL: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> cal_ok); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_valid); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R10
endmodule

// File: tb/test_afe_bringup_seq.sv
module test_afe_bringup_seq;
  localparam int unsigned CLK_HZ = 1_000_000, CHARGE_US = 40, CAL_P = 30;
  localparam int unsigned RSTC = 3, SETC = 6, TGL = 8'hEF, SBIT = 3, XCNT = 4;
  localparam logic [31:0] XADDR = {8'hFE, 8'hF3, 8'hF0, 8'hF9};
  localparam int CHARGE = CHARGE_US * (CLK_HZ / 1_000_000);
  localparam int N_TG = TGL + 1, I_SR0 = N_TG + 4, I_SR1 = N_TG + 5, I_X = N_TG + 6;
  localparam int TOTAL = I_X + XCNT;
  localparam int WD = 150000;

  logic clk = 0, rst = 1, start = 0, div3 = 0, wr_ready = 0;
  logic afe_rst_n, wr_valid, done;
  logic [7:0] wr_addr, wr_data, lut_addr, lut_data;
  logic [7:0] key = 8'h00;

  int checks = 0, errors = 0, cyc = 0;
  int n_acc, s_edge, rise_edge, first_v, a_edge, b_edge, l_edge, mode_b;
  bit seen_rise, seen_v, seen_sr1, rand_ready, stall_req;
  logic p_valid, p_done, p_rstn, p_vnr;
  logic [7:0] p_addr, p_data;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] lut(logic [7:0] a, logic [7:0] k);
    return (a * 8'd29 + k) ^ 8'hA5;
  endfunction
  assign lut_data = lut(lut_addr, key);

  function automatic logic [7:0] exp_addr(int n);
    if (n < N_TG) return 8'(n);
    if (n < I_SR0) return 8'(8'hF4 + n - N_TG);
    if (n < I_X) return 8'hF2;
    return XADDR[8*(n-I_X) +: 8];
  endfunction

  function automatic logic [7:0] exp_data(int n);
    logic [7:0] d;
    d = lut(exp_addr(n), key);
    if (n == I_SR0) d[SBIT] = 1'b0;
    if (n == I_SR1) d[SBIT] = 1'b1;
    return d;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  afe_bringup_seq #(
    .CLK_HZ(CLK_HZ), .CHARGE_US(CHARGE_US), .CAL_PERIODS(CAL_P), .RST_CYC(RSTC),
    .SETTLE_CYC(SETC), .TG_LAST(TGL), .SRST_BIT(SBIT), .EXTRA_CNT(XCNT), .EXTRA_ADDRS(XADDR)
  ) i_afe_bringup_seq (
    .clk(clk), .rst(rst), .start(start), .div3_mode(div3), .afe_rst_n(afe_rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .lut_addr(lut_addr), .lut_data(lut_data), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD) begin
      errors++;
      $display("FAIL R9 watchdog: actual cycles %0d expected below %0d", cyc, WD);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ready driver
  always begin
    @(posedge clk); #1;
    if (stall_req && n_acc == I_X) begin
      wr_ready = 1'b0;
      repeat (150) @(posedge clk);
      #1 stall_req = 1'b0;
    end else begin
      wr_ready = rand_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  // monitor, sampled on the falling edge; cyc = posedges so far
  always @(negedge clk) begin
    if (!rst) begin
      if (!p_rstn && afe_rst_n && !seen_rise) begin
        seen_rise = 1; rise_edge = cyc;
        chk(cyc - s_edge == RSTC, "R2", "reset low width", cyc - s_edge, RSTC);
      end
      if (wr_valid && !afe_rst_n)
        chk(0, "R3", "valid during hw reset", 1, 0);
      if (wr_valid && !p_valid && !seen_v) begin
        seen_v = 1; first_v = cyc;
        chk(cyc - rise_edge >= SETC, "R3", "settle gap", cyc - rise_edge, SETC);
      end
      if (wr_valid && !p_valid && n_acc == I_SR1 && !seen_sr1) begin
        seen_sr1 = 1;
        chk(cyc - a_edge >= CHARGE && cyc - a_edge <= CHARGE + 2, "R8", "charge wait",
            cyc - a_edge, CHARGE);
      end
      if (p_vnr)
        chk(wr_valid && wr_addr == p_addr && wr_data == p_data, "R4", "hold while stalled",
            int'(wr_addr), int'(p_addr));
      if (wr_valid)
        chk(lut_addr == wr_addr, "R6", "lookup address", int'(lut_addr), int'(wr_addr));
      if (wr_valid && done)
        chk(0, "R10", "write while done", 1, 0);
      if (wr_valid && wr_ready) begin
        chk(wr_addr == exp_addr(n_acc), "R5", "address order", int'(wr_addr), int'(exp_addr(n_acc)));
        chk(wr_data == exp_data(n_acc), (n_acc == I_SR0 || n_acc == I_SR1) ? "R7" : "R6",
            "write data", int'(wr_data), int'(exp_data(n_acc)));
        if (n_acc == I_SR0) a_edge = cyc + 1;
        if (n_acc == I_SR1) begin b_edge = cyc + 1; mode_b = div3; end
        l_edge = cyc + 1;
        n_acc++;
      end
      if (done && !p_done) begin
        int cal, e;
        cal = mode_b ? CAL_P * 3 : CAL_P * 2;
        e = ((l_edge > b_edge + cal) ? l_edge : b_edge + cal) + 1;
        chk(cyc == e, "R9", "done edge", cyc, e);
        chk(n_acc == TOTAL, "R5", "write count", n_acc, TOTAL);
      end
    end
    p_valid = wr_valid; p_done = done; p_rstn = afe_rst_n;
    p_vnr = wr_valid && !wr_ready; p_addr = wr_addr; p_data = wr_data;
  end

  task automatic run_seq(bit mode, bit rr, bit stall, bit poke);
    bit was_done;
    @(posedge clk); #1;
    was_done = done;
    key = 8'($urandom); div3 = mode; rand_ready = rr; stall_req = stall;
    n_acc = 0; seen_rise = 0; seen_v = 0; seen_sr1 = 0;
    a_edge = 0; b_edge = 0; l_edge = 0;
    start = 1; s_edge = cyc + 1;
    @(posedge clk); #1 start = 0;
    if (was_done) begin
      @(negedge clk);
      chk(!done && !afe_rst_n, "R10", "restart clears done", int'(done), 0);
    end
    if (poke) begin
      while (n_acc < 20) @(posedge clk);
      #1 start = 1;
      @(posedge clk); #1 start = 0;
      repeat (3) @(negedge clk);
      chk(afe_rst_n == 1'b1 && !done, "R11", "start ignored while busy", int'(afe_rst_n), 1);
    end
    while (!done) @(posedge clk);
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R10", "done sticky", int'(done), 1);
    chk(wr_valid == 1'b0, "R10", "no write after done", int'(wr_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(posedge clk);
    #1 rst = 0;
    repeat (10) @(negedge clk);
    chk(afe_rst_n == 1'b0, "R1", "reset afe_rst_n", int'(afe_rst_n), 0);
    chk(wr_valid == 1'b0, "R1", "reset wr_valid", int'(wr_valid), 0);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    run_seq(1'b0, 1'b1, 1'b0, 1'b1);   // random ready, start poked mid-run
    run_seq(1'b1, 1'b1, 1'b1, 1'b0);   // divide-by-3, long stall in table phase
    run_seq(1'b0, 1'b0, 1'b0, 1'b0);   // ready always high
    run_seq(1'b1, 1'b0, 1'b0, 1'b0);   // divide-by-3, calibration dominates
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule